// File: doc/BRIEF.md
# Pipelined SHA-256 Schedule Word Expander

This block produces one word of the SHA-256 message schedule from four earlier schedule words: the words two, seven, fifteen and sixteen positions back. It applies the two small sigma functions of the hash standard to the older and the newer operand, then sums them with the other two operands modulo 2^32. A surrounding schedule store feeds it one operand set per clock and takes the finished word back after a fixed delay.

The delay is set by a parameter to one or three register stages. With three stages, the four-way addition is split so that each stage holds at most one adder level. A new operand set is taken every cycle at either setting, and there is no stall. A qualifier bit travels through a matching chain of flops so the consumer knows which outputs carry real data. Reset is asynchronous and active low, and it empties the whole pipeline.

Top module: `sched_expand`

## Requirements
- R1: The first sigma term, applied to `w_m15`, is the XOR of that word rotated right by 7, rotated right by 18, and shifted right logically by 3. With only `w_m15` nonzero, `w_out` equals that term.
- R2: The second sigma term, applied to `w_m2`, is the XOR of that word rotated right by 17, rotated right by 19, and shifted right logically by 10. With only `w_m2` nonzero, `w_out` equals that term.
- R3: `w_out` is `w_m16` plus sigma-one(`w_m15`) plus `w_m7` plus sigma-two(`w_m2`), taken modulo 2^32. Carries out of bit 31 are discarded, and with only `w_m16` nonzero `w_out` equals `w_m16`.
- R4: The result for operands present at clock edge t appears on `w_out` after edge t+LAT-1, that is, LAT register stages later.
- R5: `out_vld` repeats `in_vld` delayed by exactly LAT clock edges, in step with the data.
- R6: While `rst_n` is low, `w_out` and `out_vld` are 0 immediately, whatever the inputs do. After release, the pipeline stages drain zeros until new operands arrive.
- R7: LAT accepts only 1 or 3, and any other value stops elaboration. Both legal settings give the same word sequence, shifted only by their latency.
- R8: A different operand set may be applied on every consecutive clock edge, and each one yields its own correct result (one result per cycle).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Qualifier that travels with the operand set |
| w_m2 | input | 32 | Schedule word two positions back |
| w_m7 | input | 32 | Schedule word seven positions back |
| w_m15 | input | 32 | Schedule word fifteen positions back |
| w_m16 | input | 32 | Schedule word sixteen positions back |
| w_out | output | 32 | New schedule word |
| out_vld | output | 1 | Delayed qualifier |

## Verification
The hardest situation to reach from the ports is a mismatch between the stage that carries the partial sum and the stage that carries the sigma sum. Such an error shows up only when the operands change on every cycle, because a stage that holds its value looks correct as long as the inputs stay still. The stimulus therefore applies long runs of different random operand sets on consecutive edges. It also walks a single set bit through `w_m15` and `w_m2` on their own, which isolates each rotation and shift amount. Finally it asserts reset in the middle of a full pipeline, to show the asynchronous clear without waiting for an edge.

// File: rtl/sched_pkg.sv
// Package: word type and the two small sigma functions of the SHA-256 schedule.
// Assumes a 32-bit word; rotation and shift amounts are fixed by the hash standard.
package sched_pkg;
    localparam int WORD_W = 32;
    localparam int S0_RA  = 7;
    localparam int S0_RB  = 18;
    localparam int S0_SH  = 3;
    localparam int S1_RA  = 17;
    localparam int S1_RB  = 19;
    localparam int S1_SH  = 10;

    typedef logic [WORD_W-1:0] word_t;

    // Rotate a word right by n positions (0 < n < WORD_W).
    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    // Sigma applied to the word fifteen positions back.
    function automatic word_t sig_old(input word_t x);
        return rotr(x, S0_RA) ^ rotr(x, S0_RB) ^ (x >> S0_SH);
    endfunction

    // Sigma applied to the word two positions back.
    function automatic word_t sig_new(input word_t x);
        return rotr(x, S1_RA) ^ rotr(x, S1_RB) ^ (x >> S1_SH);
    endfunction
endpackage

// File: rtl/sched_reg.sv
// Module: plain pipeline register with asynchronous active-low clear.
// Assumes the clear value is all zeros; no enable, it loads every cycle.
module sched_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture d on each rising edge, clear at once when reset falls.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/sched_sigma.sv
// Module: combinational sigma unit; USE_NEW picks the variant for the
// word two positions back (1) or fifteen positions back (0).
// Assumes the caller registers the result where timing needs it.
module sched_sigma
    import sched_pkg::*;
#(
    parameter bit USE_NEW = 1'b0
) (
    input  word_t x,
    output word_t y
);
    generate
        if (USE_NEW) begin : g_new
            // Rotations 17/19 and shift 10.
            always_comb y = sig_new(x);
        end else begin : g_old
            // Rotations 7/18 and shift 3.
            always_comb y = sig_old(x);
        end
    endgenerate
endmodule

// File: rtl/sched_expand.sv
// Module: one SHA-256 schedule word from words i-2, i-7, i-15, i-16.
// LAT = 3 splits the four-way sum over three register stages; LAT = 1 does
// it in one combinational level into a single output register. Takes a new
// operand set every cycle, has no stall, and its reset is asynchronous and active low.
module sched_expand
    import sched_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_vld,
    input  logic [31:0] w_m2,
    input  logic [31:0] w_m7,
    input  logic [31:0] w_m15,
    input  logic [31:0] w_m16,
    output logic [31:0] w_out,
    output logic        out_vld
);
    localparam int VCH_W = LAT + 1;

    word_t sg_old;
    word_t sg_new;
    logic [VCH_W-1:0] vchain;

    sched_sigma #(.USE_NEW(1'b0)) u_sig_old (.x(w_m15), .y(sg_old));
    sched_sigma #(.USE_NEW(1'b1)) u_sig_new (.x(w_m2),  .y(sg_new));

    generate
        if (LAT == 3) begin : g_deep
            word_t st1_old, st1_new, st1_part;
            word_t st2_sig, st2_part;
            // Stage 1: hold both sigmas and the partial sum of the plain operands.
            sched_reg #(.W(WORD_W)) u_s1_old  (.clk(clk), .rst_n(rst_n), .d(sg_old), .q(st1_old));
            sched_reg #(.W(WORD_W)) u_s1_new  (.clk(clk), .rst_n(rst_n), .d(sg_new), .q(st1_new));
            sched_reg #(.W(WORD_W)) u_s1_part (.clk(clk), .rst_n(rst_n), .d(w_m16 + w_m7), .q(st1_part));
            // Stage 2: add the two sigmas, carry the partial sum along.
            sched_reg #(.W(WORD_W)) u_s2_sig  (.clk(clk), .rst_n(rst_n), .d(st1_old + st1_new), .q(st2_sig));
            sched_reg #(.W(WORD_W)) u_s2_part (.clk(clk), .rst_n(rst_n), .d(st1_part), .q(st2_part));
            // Stage 3: final modulo-2^32 addition.
            sched_reg #(.W(WORD_W)) u_s3      (.clk(clk), .rst_n(rst_n), .d(st2_sig + st2_part), .q(w_out));
        end else if (LAT == 1) begin : g_flat
            // Single stage: the whole sum into the output register.
            sched_reg #(.W(WORD_W)) u_s1 (.clk(clk), .rst_n(rst_n),
                                          .d(w_m16 + sg_old + w_m7 + sg_new), .q(w_out));
        end else begin : g_bad
            $error("sched_expand: LAT must be 1 or 3");
        end
    endgenerate

    // Qualifier chain, one flop per data stage.
    assign vchain[0] = in_vld;
    generate
        for (genvar k = 0; k < LAT; k++) begin : g_vld
            sched_reg #(.W(1)) u_v (.clk(clk), .rst_n(rst_n), .d(vchain[k]), .q(vchain[k+1]));
        end
    endgenerate
    assign out_vld = vchain[LAT];
endmodule

// File: rtl/sched_expand_chk.sv
// Checker for sched_expand: latency, qualifier alignment, the pass-through
// of the sixteen-back operand, and the reset clear. Bound to every instance.
module sched_expand_chk
    import sched_pkg::*;
#(
    parameter int LAT = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_vld,
    input logic [31:0] w_m2,
    input logic [31:0] w_m7,
    input logic [31:0] w_m15,
    input logic [31:0] w_m16,
    input logic [31:0] w_out,
    input logic        out_vld
);
    int unsigned since_rst;
    word_t       expect_now;

    // Count edges since reset release, saturating at LAT.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= 0;
        else if (since_rst < LAT) since_rst <= since_rst + 1;
    end

    // Spec value for the operands present now.
    always_comb expect_now = w_m16 + sig_old(w_m15) + w_m7 + sig_new(w_m2);

    // R4
    data_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= LAT) |-> (w_out == $past(expect_now, LAT)));

    // R5
    vld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= LAT) |-> (out_vld == $past(in_vld, LAT)));

    // R3
    pass_m16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= LAT && $past(w_m2 | w_m7 | w_m15, LAT) == '0)
            |-> (w_out == $past(w_m16, LAT)));

    // R6
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (w_out == '0 && !out_vld));
endmodule

bind sched_expand sched_expand_chk #(.LAT(LAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .w_m2(w_m2), .w_m7(w_m7), .w_m15(w_m15), .w_m16(w_m16),
    .w_out(w_out), .out_vld(out_vld)
);

// File: tb/sched_expand_tb.sv
// Bench: two instances (LAT 3 and LAT 1) share one stimulus stream; a
// behavioural queue model predicts every output and is compared each cycle.
module sched_expand_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] w_m2 = '0, w_m7 = '0, w_m15 = '0, w_m16 = '0;
    logic [31:0] out3, out1;
    logic        vld3, vld1;

    int nvec = 0;
    int nfail = 0;
    logic [32:0] hist[$];

    always #5 clk = ~clk;

    sched_expand #(.LAT(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .w_m2(w_m2), .w_m7(w_m7), .w_m15(w_m15), .w_m16(w_m16),
        .w_out(out3), .out_vld(vld3));

    sched_expand #(.LAT(1)) u_dut1 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .w_m2(w_m2), .w_m7(w_m7), .w_m15(w_m15), .w_m16(w_m16),
        .w_out(out1), .out_vld(vld1));

    function automatic logic [31:0] ror(input logic [31:0] x, input int n);
        logic [63:0] dbl;
        dbl = {x, x} >> n;
        return dbl[31:0];
    endfunction

    function automatic logic [31:0] model(input logic [31:0] a2, a7, a15, a16);
        logic [31:0] s_old, s_new;
        s_old = ror(a15, 7) ^ ror(a15, 18) ^ (a15 >> 3);
        s_new = ror(a2, 17) ^ ror(a2, 19) ^ (a2 >> 10);
        return a16 + s_old + a7 + s_new;
    endfunction

    task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got vld=%0b w=%08h expected vld=%0b w=%08h",
                     tag, got[32], got[31:0], exp[32], exp[31:0]);
        end
    endtask

    task automatic prime();
        hist.delete();
        repeat (3) hist.push_back('0);
    endtask

    // Apply one operand set at a falling edge, model the capture, compare both instances.
    task automatic step(input logic v, input logic [31:0] a2, a7, a15, a16, input string tag);
        in_vld = v; w_m2 = a2; w_m7 = a7; w_m15 = a15; w_m16 = a16;
        @(posedge clk);
        hist.push_back({v, model(a2, a7, a15, a16)});
        @(negedge clk);
        check(tag,  {vld3, out3}, hist[hist.size()-3]);
        check("R7", {vld1, out1}, hist[hist.size()-1]);
        if (hist.size() > 8) void'(hist.pop_front());
    endtask

    initial begin
        #(100000 * 10);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        // R6: reset state, with busy inputs that must not get through.
        repeat (2) @(negedge clk);
        in_vld = 1'b1; w_m2 = 32'h1234_5678; w_m7 = 32'hffff_ffff; w_m15 = 32'h8000_0001; w_m16 = 32'h0f0f_0f0f;
        repeat (2) @(negedge clk);
        check("R6", {vld3, out3}, '0);
        check("R6", {vld1, out1}, '0);
        rst_n = 1'b1;
        prime();

        // R1: single bit walking through the fifteen-back operand.
        for (int b = 0; b < 32; b++) step(1'b1, 32'h0, 32'h0, 32'd1 << b, 32'h0, "R1");
        // R2: single bit walking through the two-back operand.
        for (int b = 0; b < 32; b++) step(1'b1, 32'd1 << b, 32'h0, 32'h0, 32'h0, "R2");
        // R3: carries and wrap.
        step(1'b1, 32'hffff_ffff, 32'hffff_ffff, 32'hffff_ffff, 32'hffff_ffff, "R3");
        step(1'b1, 32'h0, 32'hffff_ffff, 32'h0, 32'h0000_0001, "R3");
        step(1'b1, 32'h0, 32'h0, 32'h0, 32'hdead_beef, "R3");
        step(1'b1, 32'h0, 32'h8000_0000, 32'h0, 32'h8000_0000, "R3");
        // R8: a different set on every edge, qualifier held high.
        for (int i = 0; i < 40; i++) step(1'b1, $urandom, $urandom, $urandom, $urandom, "R8");
        // R5: qualifier toggling at random.
        for (int i = 0; i < 60; i++) step(1'($urandom_range(0, 1)), $urandom, $urandom, $urandom, $urandom, "R5");
        // R4: long random run.
        for (int i = 0; i < 300; i++) step(1'($urandom_range(0, 1)), $urandom, $urandom, $urandom, $urandom, "R4");

        // R6: reset in the middle of a full pipeline clears at once.
        in_vld = 1'b1; w_m2 = $urandom; w_m7 = $urandom; w_m15 = $urandom; w_m16 = $urandom;
        rst_n = 1'b0;
        #1;
        check("R6", {vld3, out3}, '0);
        check("R6", {vld1, out1}, '0);
        @(negedge clk);
        check("R6", {vld3, out3}, '0);
        check("R6", {vld1, out1}, '0);
        rst_n = 1'b1;
        prime();
        for (int i = 0; i < 20; i++) step(1'b1, $urandom, $urandom, $urandom, $urandom, "R4");
        for (int i = 0; i < 4; i++) step(1'b0, 32'h0, 32'h0, 32'h0, 32'h0, "R5");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule